// File: doc/BRIEF.md
# JTAG-Driven Wishbone Memory Access Bridge

This block is a JTAG test access port whose private instructions let an external debugger drive single Wishbone transfers on the system bus. It has a 4-bit instruction register and a 16-state TAP controller. A debugger first scans a word address into an address register. It then runs 32-bit data scans: a plain read returns the word at the current address, and a swap writes the scanned-in word there while returning the word that was stored before. The address steps by one word after every data access, so a run of scans walks through consecutive locations.

Each Update-DR of a memory instruction raises a request that moves by toggle from the test clock domain into the system clock domain. There a small master runs one classic Wishbone cycle, or a write followed by a read, and hands the read word and a completion toggle back. The block always fetches the word at the new current address ahead of time, so the next Capture-DR loads it without waiting. The test clock must be slow enough relative to the system clock for that fetch to finish before the next capture. IDCODE and BYPASS work as usual, and Test-Logic-Reset selects IDCODE.

Top module: `jtag_wb_bridge`

## Requirements
- R1: An active-low trst_ni, or five TCK cycles with TMS high, puts the TAP in Test-Logic-Reset and selects the IDCODE instruction (code 0001). A 32-bit data scan then returns the IDCODE parameter value, least significant bit first.
- R2: Capture-IR loads the pattern 0001, so the first four bits shifted out of the instruction register are 1, 0, 0, 0.
- R3: BYPASS (1111) and every code not named here select a 1-bit register that captures 0. TDI reaches TDO one TCK later.
- R4: Code 0101 selects the AW-bit address register. Capture-DR presents the current address, and Update-DR loads the scanned-in word address.
- R5: Code 0110 (read) makes each 32-bit scan return the word at the current address. No Wishbone write is issued.
- R6: Code 0111 (swap) makes each 32-bit scan return the word stored at the current address. On Update-DR the scanned-in word is written to that address.
- R7: After every Update-DR under read or swap, the address increases by one and wraps modulo 2^AW.
- R8: Wishbone cycles carry CYC = STB = 1 and every SEL bit set. Address, data and WE stay unchanged until ACK, and CYC is low after reset.
- R9: Each memory Update-DR issues a read of the new current address. Its data is what the next Capture-DR loads, given at least four TCK cycles in Run-Test/Idle after Update-DR and a TCK period of at least eight system clocks.
- R10: A swap is carried out as a write at the current address, then in the next system cycle a read of the following address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Test data in |
| trst_ni | input | 1 | Asynchronous TAP reset, active low |
| tdo_o | output | 1 | Test data out, changes on falling TCK |
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | System reset, active low |
| wb_adr_o | output | AW | Word address |
| wb_dat_o | output | DW | Write data |
| wb_dat_i | input | DW | Read data |
| wb_sel_o | output | DW/8 | Byte selects |
| wb_we_o | output | 1 | Write enable |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Strobe |
| wb_ack_i | input | 1 | Acknowledge |

## Verification
The bench builds the bridge with AW = 4, which leaves a 16-word memory. Every location can therefore be swapped twice and read once, and both the wraparound of the address counter and a reload at a mid-range start point are reached in a few dozen scans. Expected words come from formulas for the initial fill and for alternating 0x55555555 / 0xAAAAAAAA patterns. A bus monitor counts writes, so it can show that read scans leave memory untouched.

// File: rtl/jwb_pkg.sv
package jwb_pkg;

   typedef enum logic [3:0] {
      TS_RESET, TS_IDLE,
      TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
      TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
   } tap_state_e;

   typedef enum logic [2:0] {
      DS_BYPASS, DS_IDCODE, DS_ADDR, DS_READ, DS_SWAP
   } dr_sel_e;

   typedef enum logic [1:0] {
      MS_IDLE, MS_WRITE, MS_READ
   } mst_state_e;

   function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
      case (s)
         TS_RESET:  return tms ? TS_RESET  : TS_IDLE;
         TS_IDLE:   return tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_DR: return tms ? TS_SEL_IR : TS_CAP_DR;
         TS_CAP_DR: return tms ? TS_EX1_DR : TS_SHF_DR;
         TS_SHF_DR: return tms ? TS_EX1_DR : TS_SHF_DR;
         TS_EX1_DR: return tms ? TS_UPD_DR : TS_PAU_DR;
         TS_PAU_DR: return tms ? TS_EX2_DR : TS_PAU_DR;
         TS_EX2_DR: return tms ? TS_UPD_DR : TS_SHF_DR;
         TS_UPD_DR: return tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_IR: return tms ? TS_RESET  : TS_CAP_IR;
         TS_CAP_IR: return tms ? TS_EX1_IR : TS_SHF_IR;
         TS_SHF_IR: return tms ? TS_EX1_IR : TS_SHF_IR;
         TS_EX1_IR: return tms ? TS_UPD_IR : TS_PAU_IR;
         TS_PAU_IR: return tms ? TS_EX2_IR : TS_PAU_IR;
         TS_EX2_IR: return tms ? TS_UPD_IR : TS_SHF_IR;
         TS_UPD_IR: return tms ? TS_SEL_DR : TS_IDLE;
         default:   return TS_RESET;
      endcase
   endfunction

endpackage

// File: rtl/jwb_sync.sv
module jwb_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] ff_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) ff_q[g] <= 1'b0;
            else         ff_q[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) ff_q[g] <= 1'b0;
            else         ff_q[g] <= ff_q[g-1];
         end
      end
   end

   assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/jwb_tap_ctrl.sv
module jwb_tap_ctrl
   import jwb_pkg::*;
(
   input  logic       tck_i,
   input  logic       trst_ni,
   input  logic       tms_i,
   output tap_state_e state_o
);
   tap_state_e st_q;

   always_ff @(posedge tck_i or negedge trst_ni) begin
      if (!trst_ni) st_q <= TS_RESET;
      else          st_q <= tap_next(st_q, tms_i);
   end

   assign state_o = st_q;
endmodule

// File: rtl/jwb_wb_master.sv
module jwb_wb_master
   import jwb_pkg::*;
#(
   parameter int unsigned AW          = 30,
   parameter int unsigned DW          = 32,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned SW         = DW / 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          req_tgl_i,
   input  logic [AW-1:0] req_adr_i,
   input  logic [DW-1:0] req_dat_i,
   input  logic          req_we_i,
   output logic          done_tgl_o,
   output logic [DW-1:0] rdata_o,
   output logic [AW-1:0] wb_adr_o,
   output logic [DW-1:0] wb_dat_o,
   input  logic [DW-1:0] wb_dat_i,
   output logic [SW-1:0] wb_sel_o,
   output logic          wb_we_o,
   output logic          wb_cyc_o,
   output logic          wb_stb_o,
   input  logic          wb_ack_i
);
   mst_state_e    st_q;
   logic          req_s, seen_q, cyc_q, we_q, done_q;
   logic [AW-1:0] adr_q;
   logic [DW-1:0] dat_q, rd_q;

   jwb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk_i (clk_i), .rst_ni(rst_ni), .d_i(req_tgl_i), .q_o(req_s)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= MS_IDLE;
         seen_q <= 1'b0;
         cyc_q  <= 1'b0;
         we_q   <= 1'b0;
         done_q <= 1'b0;
         adr_q  <= '0;
         dat_q  <= '0;
         rd_q   <= '0;
      end else begin
         case (st_q)
            MS_IDLE: if (req_s != seen_q) begin
               seen_q <= req_s;
               cyc_q  <= 1'b1;
               adr_q  <= req_adr_i;
               dat_q  <= req_dat_i;
               we_q   <= req_we_i;
               st_q   <= req_we_i ? MS_WRITE : MS_READ;
            end
            MS_WRITE: if (wb_ack_i) begin
               we_q  <= 1'b0;
               adr_q <= adr_q + AW'(1);
               st_q  <= MS_READ;
            end
            MS_READ: if (wb_ack_i) begin
               cyc_q  <= 1'b0;
               rd_q   <= wb_dat_i;
               done_q <= ~done_q;
               st_q   <= MS_IDLE;
            end
            default: st_q <= MS_IDLE;
         endcase
      end
   end

   assign wb_adr_o   = adr_q;
   assign wb_dat_o   = dat_q;
   assign wb_we_o    = we_q;
   assign wb_cyc_o   = cyc_q;
   assign wb_stb_o   = cyc_q;
   assign wb_sel_o   = {SW{1'b1}};
   assign done_tgl_o = done_q;
   assign rdata_o    = rd_q;
endmodule

// File: rtl/jtag_wb_bridge.sv
module jtag_wb_bridge
   import jwb_pkg::*;
#(
   parameter int unsigned IR_W        = 4,
   parameter int unsigned AW          = 30,
   parameter int unsigned DW          = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          TDO_FALL    = 1'b1,
   parameter logic [31:0] IDCODE_VAL  = 32'h1B7A_C0DF,
   parameter int unsigned OP_IDCODE   = 1,
   parameter int unsigned OP_ADDR     = 5,
   parameter int unsigned OP_READ     = 6,
   parameter int unsigned OP_SWAP     = 7,
   localparam int unsigned SW         = DW / 8,
   localparam int unsigned LW         = $clog2(DW + 1)
) (
   input  logic          tck_i,
   input  logic          tms_i,
   input  logic          tdi_i,
   input  logic          trst_ni,
   output logic          tdo_o,
   input  logic          clk_i,
   input  logic          rst_ni,
   output logic [AW-1:0] wb_adr_o,
   output logic [DW-1:0] wb_dat_o,
   input  logic [DW-1:0] wb_dat_i,
   output logic [SW-1:0] wb_sel_o,
   output logic          wb_we_o,
   output logic          wb_cyc_o,
   output logic          wb_stb_o,
   input  logic          wb_ack_i
);
   // elaboration checks
   if (IR_W < 3) begin : g_bad_ir
      $error("IR_W must be at least 3");
   end
   if (DW < 32 || (DW % 8) != 0) begin : g_bad_dw
      $error("DW must be a multiple of 8 and at least 32");
   end
   if (AW > DW || AW < 1) begin : g_bad_aw
      $error("AW must lie in 1..DW");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (OP_ADDR >= (1 << IR_W) || OP_READ >= (1 << IR_W) ||
       OP_SWAP >= (1 << IR_W) || OP_IDCODE >= (1 << IR_W)) begin : g_bad_op
      $error("opcode does not fit the instruction register");
   end

   tap_state_e    tap_st;
   dr_sel_e       dsel;
   logic [IR_W-1:0] ir_sr, ir_q;
   logic [DW-1:0] dr_sr, shift_nxt, len_mask;
   logic [LW-1:0] dr_len;
   logic [AW-1:0] addr_q, req_adr;
   logic [DW-1:0] req_dat, rd_hold, sys_rdata;
   logic          req_we, req_tgl, done_tgl, done_s, tdo_q, tdo_src;

   jwb_tap_ctrl u_tap (
      .tck_i(tck_i), .trst_ni(trst_ni), .tms_i(tms_i), .state_o(tap_st)
   );

   // instruction decode
   always_comb begin
      if      (ir_q == IR_W'(OP_ADDR))   dsel = DS_ADDR;
      else if (ir_q == IR_W'(OP_READ))   dsel = DS_READ;
      else if (ir_q == IR_W'(OP_SWAP))   dsel = DS_SWAP;
      else if (ir_q == IR_W'(OP_IDCODE)) dsel = DS_IDCODE;
      else                               dsel = DS_BYPASS;
   end

   always_comb begin
      case (dsel)
         DS_ADDR:           dr_len = LW'(AW);
         DS_READ, DS_SWAP:  dr_len = LW'(DW);
         DS_IDCODE:         dr_len = LW'(32);
         default:           dr_len = LW'(1);
      endcase
      len_mask  = (DW'(1) << (dr_len - LW'(1))) - DW'(1);
      shift_nxt = ((dr_sr >> 1) & len_mask) | (DW'(tdi_i) << (dr_len - LW'(1)));
   end

   always_ff @(posedge tck_i or negedge trst_ni) begin
      if (!trst_ni) begin
         ir_sr   <= '0;
         ir_q    <= IR_W'(OP_IDCODE);
         dr_sr   <= '0;
         addr_q  <= '0;
         req_tgl <= 1'b0;
         req_adr <= '0;
         req_dat <= '0;
         req_we  <= 1'b0;
      end else begin
         case (tap_st)
            TS_RESET:  ir_q  <= IR_W'(OP_IDCODE);
            TS_CAP_IR: ir_sr <= IR_W'(2'b01);
            TS_SHF_IR: ir_sr <= {tdi_i, ir_sr[IR_W-1:1]};
            TS_UPD_IR: ir_q  <= ir_sr;
            TS_CAP_DR: begin
               case (dsel)
                  DS_ADDR:          dr_sr <= DW'(addr_q);
                  DS_READ, DS_SWAP: dr_sr <= rd_hold;
                  DS_IDCODE:        dr_sr <= DW'(IDCODE_VAL);
                  default:          dr_sr <= '0;
               endcase
            end
            TS_SHF_DR: dr_sr <= shift_nxt;
            TS_UPD_DR: begin
               case (dsel)
                  DS_ADDR: begin
                     addr_q  <= dr_sr[AW-1:0];
                     req_adr <= dr_sr[AW-1:0];
                     req_we  <= 1'b0;
                     req_tgl <= ~req_tgl;
                  end
                  DS_READ: begin
                     addr_q  <= addr_q + AW'(1);
                     req_adr <= addr_q + AW'(1);
                     req_we  <= 1'b0;
                     req_tgl <= ~req_tgl;
                  end
                  DS_SWAP: begin
                     addr_q  <= addr_q + AW'(1);
                     req_adr <= addr_q;
                     req_dat <= dr_sr;
                     req_we  <= 1'b1;
                     req_tgl <= ~req_tgl;
                  end
                  default: ;
               endcase
            end
            default: ;
         endcase
      end
   end

   // prefetched word crosses back once the completion toggle matches
   jwb_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
      .clk_i(tck_i), .rst_ni(trst_ni), .d_i(done_tgl), .q_o(done_s)
   );

   always_ff @(posedge tck_i or negedge trst_ni) begin
      if (!trst_ni)               rd_hold <= '0;
      else if (done_s == req_tgl) rd_hold <= sys_rdata;
   end

   assign tdo_src = (tap_st == TS_SHF_IR) ? ir_sr[0] : dr_sr[0];

   if (TDO_FALL) begin : g_tdo_fall
      always_ff @(negedge tck_i or negedge trst_ni) begin
         if (!trst_ni) tdo_q <= 1'b0;
         else if (tap_st == TS_SHF_IR || tap_st == TS_SHF_DR) tdo_q <= tdo_src;
      end
   end else begin : g_tdo_rise
      always_ff @(posedge tck_i or negedge trst_ni) begin
         if (!trst_ni) tdo_q <= 1'b0;
         else if (tap_st == TS_CAP_IR || tap_st == TS_CAP_DR) tdo_q <= 1'b0;
         else if (tap_st == TS_SHF_IR || tap_st == TS_SHF_DR) tdo_q <= tdo_src;
      end
   end
   assign tdo_o = tdo_q;

   jwb_wb_master #(.AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_mst (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_tgl_i (req_tgl),
      .req_adr_i (req_adr),
      .req_dat_i (req_dat),
      .req_we_i  (req_we),
      .done_tgl_o(done_tgl),
      .rdata_o   (sys_rdata),
      .wb_adr_o  (wb_adr_o),
      .wb_dat_o  (wb_dat_o),
      .wb_dat_i  (wb_dat_i),
      .wb_sel_o  (wb_sel_o),
      .wb_we_o   (wb_we_o),
      .wb_cyc_o  (wb_cyc_o),
      .wb_stb_o  (wb_stb_o),
      .wb_ack_i  (wb_ack_i)
   );
endmodule

// File: rtl/jwb_checker.sv
module jwb_checker
   import jwb_pkg::*;
#(
   parameter int unsigned IR_W      = 4,
   parameter int unsigned AW        = 30,
   parameter int unsigned DW        = 32,
   parameter int unsigned OP_IDCODE = 1,
   parameter int unsigned OP_ADDR   = 5,
   parameter int unsigned OP_READ   = 6,
   parameter int unsigned OP_SWAP   = 7
) (
   input logic            tck_i,
   input logic            trst_ni,
   input logic            clk_i,
   input logic            rst_ni,
   input tap_state_e      tap_st,
   input logic [IR_W-1:0] ir_q,
   input logic [AW-1:0]   addr_q,
   input logic            req_tgl,
   input logic            done_tgl,
   input logic [AW-1:0]   wb_adr_o,
   input logic [DW-1:0]   wb_dat_o,
   input logic            wb_we_o,
   input logic            wb_cyc_o,
   input logic            wb_ack_i
);
   logic mem_op, data_op;
   assign data_op = (ir_q == IR_W'(OP_READ)) || (ir_q == IR_W'(OP_SWAP));
   assign mem_op  = data_op || (ir_q == IR_W'(OP_ADDR));

   AST_RESET_PICKS_ID: assert property (@(posedge tck_i) disable iff (!trst_ni)
      tap_st == TS_RESET |=> ir_q == IR_W'(OP_IDCODE)); // R1

   AST_ADDR_STEP: assert property (@(posedge tck_i) disable iff (!trst_ni)
      (tap_st == TS_UPD_DR && data_op) |=> (addr_q - $past(addr_q)) == AW'(1)); // R7

   AST_UPDATE_REQUESTS: assert property (@(posedge tck_i) disable iff (!trst_ni)
      (tap_st == TS_UPD_DR && mem_op) |=> req_tgl != $past(req_tgl)); // R9

   AST_HOLD_TILL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wb_cyc_o && !wb_ack_i) |=> wb_cyc_o && $stable(wb_adr_o) && $stable(wb_we_o)
                                  && $stable(wb_dat_o)); // R8

   AST_SWAP_THEN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wb_cyc_o && wb_we_o && wb_ack_i) |=> wb_cyc_o && !wb_we_o
                                            && (wb_adr_o - $past(wb_adr_o)) == AW'(1)); // R10

   AST_DONE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wb_cyc_o && !wb_we_o && wb_ack_i) |=> !wb_cyc_o && done_tgl != $past(done_tgl)); // R9
endmodule

bind jtag_wb_bridge jwb_checker #(
   .IR_W(IR_W), .AW(AW), .DW(DW), .OP_IDCODE(OP_IDCODE),
   .OP_ADDR(OP_ADDR), .OP_READ(OP_READ), .OP_SWAP(OP_SWAP)
) u_jwb_chk (
   .tck_i   (tck_i),
   .trst_ni (trst_ni),
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .tap_st  (tap_st),
   .ir_q    (ir_q),
   .addr_q  (addr_q),
   .req_tgl (req_tgl),
   .done_tgl(done_tgl),
   .wb_adr_o(wb_adr_o),
   .wb_dat_o(wb_dat_o),
   .wb_we_o (wb_we_o),
   .wb_cyc_o(wb_cyc_o),
   .wb_ack_i(wb_ack_i)
);

// File: tb/jtag_wb_bridge_test.sv
module jtag_wb_bridge_test;
   localparam int unsigned BAW   = 4;
   localparam int unsigned NWORD = 1 << BAW;
   localparam logic [31:0] IDV   = 32'h1B7A_C0DF;

   logic clk_i = 1'b0, rst_ni = 1'b0;
   logic tck_i = 1'b0, tms_i = 1'b1, tdi_i = 1'b0, trst_ni = 1'b0;
   logic tdo_o;
   logic [BAW-1:0] wb_adr_o;
   logic [31:0] wb_dat_o, wb_dat_i;
   logic [3:0]  wb_sel_o;
   logic wb_we_o, wb_cyc_o, wb_stb_o, wb_ack_i;

   int n_cmp = 0, n_bad = 0, n_writes = 0, sel_bad = 0;
   bit finished = 1'b0;
   logic [31:0] mem [NWORD];

   always #2 clk_i = ~clk_i;

   jtag_wb_bridge #(.AW(BAW), .IDCODE_VAL(IDV)) uut (
      .tck_i(tck_i), .tms_i(tms_i), .tdi_i(tdi_i), .trst_ni(trst_ni), .tdo_o(tdo_o),
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_sel_o(wb_sel_o),
      .wb_we_o(wb_we_o), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_ack_i(wb_ack_i)
   );

   function automatic logic [31:0] init_w(input int i);
      return 32'h0F0F_0000 + 32'(i);
   endfunction
   function automatic logic [31:0] pat(input int i);
      return (i % 2 == 1) ? 32'hAAAA_AAAA : 32'h5555_5555;
   endfunction

   // memory model: one-cycle ack
   always @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int i = 0; i < NWORD; i++) mem[i] <= init_w(i);
         wb_ack_i <= 1'b0;
         wb_dat_i <= '0;
         n_writes <= 0;
      end else if (wb_cyc_o && wb_stb_o && !wb_ack_i) begin
         wb_ack_i <= 1'b1;
         if (wb_we_o) begin
            mem[wb_adr_o] <= wb_dat_o;
            n_writes <= n_writes + 1;
         end else begin
            wb_dat_i <= mem[wb_adr_o];
         end
      end else begin
         wb_ack_i <= 1'b0;
      end
   end

   always @(negedge clk_i)
      if (rst_ni && wb_cyc_o && (wb_stb_o !== 1'b1 || wb_sel_o !== 4'hF)) sel_bad <= sel_bad + 1;

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic tck_step(input logic tms, input logic tdi, output logic tdo_s);
      tms_i = tms;
      tdi_i = tdi;
      #20;
      tdo_s = tdo_o;
      tck_i = 1'b1;
      #20;
      tck_i = 1'b0;
   endtask

   task automatic go(input logic tms);
      logic d;
      tck_step(tms, 1'b0, d);
   endtask

   task automatic scan_ir(input logic [3:0] code, output logic [3:0] got);
      logic b;
      go(1); go(1); go(0); go(0);
      for (int i = 0; i < 4; i++) begin
         tck_step(i == 3, code[i], b);
         got[i] = b;
      end
      go(1); go(0);
      repeat (4) go(0);
   endtask

   task automatic scan_dr(input logic [31:0] din, input int len, output logic [31:0] dout);
      logic b;
      dout = '0;
      go(1); go(0); go(0);
      for (int i = 0; i < len; i++) begin
         tck_step(i == len - 1, din[i], b);
         dout[i] = b;
      end
      go(1); go(0);
      repeat (4) go(0);
   endtask

   initial begin
      logic [3:0]  ir_out;
      logic [31:0] out;
      int wc;
      repeat (5) @(posedge clk_i);
      @(negedge clk_i);
      trst_ni = 1'b1;
      rst_ni  = 1'b1;
      @(negedge clk_i);
      check("R8 reset cyc", 32'(wb_cyc_o), 32'd0);
      go(0);

      scan_dr(32'h0, 32, out);
      check("R1 idcode after trst", out, IDV);

      scan_ir(4'hF, ir_out);
      check("R2 capture-ir", 32'(ir_out), 32'h1);
      scan_dr(32'hA5, 8, out);
      check("R3 bypass", out, 32'h4A);
      scan_ir(4'h3, ir_out);
      scan_dr(32'h3C, 6, out);
      check("R3 unused code", out, 32'h38);

      repeat (5) go(1);
      go(0);
      scan_dr(32'h0, 32, out);
      check("R1 idcode after tms reset", out, IDV);

      scan_ir(4'h5, ir_out);
      scan_dr(32'h0, BAW, out);
      check("R4 reset address", out, 32'h0);

      scan_ir(4'h7, ir_out);
      for (int i = 0; i < NWORD; i++) begin
         scan_dr(pat(i), 32, out);
         check("R6 swap pass1", out, init_w(i));
      end
      scan_ir(4'h5, ir_out);
      scan_dr(32'h0, BAW, out);
      check("R7 wrap after sweep", out, 32'h0);

      scan_ir(4'h7, ir_out);
      for (int i = 0; i < NWORD; i++) begin
         scan_dr(~pat(i), 32, out);
         check("R6 swap pass2", out, pat(i));
      end

      scan_ir(4'h5, ir_out);
      scan_dr(32'h5, BAW, out);
      check("R4 capture before load", out, 32'h0);
      scan_ir(4'h6, ir_out);
      wc = n_writes;
      for (int i = 0; i < NWORD; i++) begin
         scan_dr(32'h0, 32, out);
         check("R5 R9 read sweep", out, ~pat((i + 5) % NWORD));
      end
      check("R5 no writes during read", 32'(n_writes), 32'(wc));
      scan_ir(4'h5, ir_out);
      scan_dr(32'h9, BAW, out);
      check("R7 wrap to start", out, 32'h5);

      check("R8 sel/stb", 32'(sel_bad), 32'd0);
      check("R10 write count", 32'(n_writes), 32'(2 * NWORD));

      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk_i);
      if (!finished) begin
         finished = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule